// File: doc/BRIEF.md
# Dual-Mode Serial Transmitter

This block is the transmit half of a serial port. One shift engine sends frames either as an asynchronous line (start bit, data least significant bit first, optional ninth bit, stop bit) or as a half-duplex clocked link. On the clocked link the block either generates the bit clock itself (master) or follows a clock from outside (slave). An 8-bit control and status register selects the mode, the frame length, the bit timing and the transmit enable. It also holds the software-supplied ninth bit and reports whether the shift register is empty.

Bytes enter through a one-entry holding stage with a valid/ready handshake. A beat is taken on a rising clock edge where `data_valid` and `data_ready` are both high. `data_ready` then stays low until the engine moves the byte into the shift register, which is the back-pressure a source must respect. `data_in` must remain stable while `data_valid` is high and `data_ready` is low. Bit timing comes from an external rate tick.

The register is laid out as follows. Bit 7 selects the clock source in synchronous mode (1 = master). Bit 6 enables 9-bit frames. Bit 5 enables transmit. Bit 4 selects the mode (1 = synchronous). Bit 3 reads as 0. Bit 2 selects high-speed asynchronous timing. Bit 1 is the read-only empty flag. Bit 0 is the ninth data bit.

Top module: `dual_serial_tx`

## Requirements
- R1: After reset `csr_rdata` reads 8'h02: every control field is 0 and the empty flag (bit 1) is 1. `txd` is 1, `sclk_o` and `sclk_oe` are 0, and `data_ready` is 1.
- R2: Bits 7, 6, 5, 4, 2 and 0 are written by `csr_wr_en` with `csr_wdata` and read back. Bit 3 always reads 0. Writes to bit 1 are ignored.
- R3: `data_ready` is high exactly when the holding stage is empty. After a beat is taken, `data_ready` is low until the byte is loaded, and a full holding stage keeps its byte.
- R4: In asynchronous mode (bit 4 = 0) with bit 2 = 0, a frame is one 0 start bit, then the data LSB first, then one 1 stop bit. Each bit lasts 64 rate ticks, and the line changes only after a tick.
- R5: With bit 2 = 1 in asynchronous mode, each bit lasts 16 rate ticks.
- R6: With bit 6 = 1, the value of bit 0 at load time is sent after the eighth data bit in both modes. In asynchronous mode it comes before the stop bit.
- R7: A byte loads on the first edge where the engine is idle, the holding stage is full and sending is allowed (in master and asynchronous modes that edge must also carry a tick). Loading clears the empty flag. The flag sets again on the edge that ends the last bit.
- R8: In synchronous master mode (bits 4 = 1 and 7 = 1), `sclk_oe` is 1 and the clock idles low. The clock toggles on each tick, and data advances on each falling edge, so each bit lasts two ticks. Bit 2 has no effect.
- R9: In synchronous slave mode (bit 4 = 1, bit 7 = 0), `sclk_oe` is 0. A byte loads without a tick, and the data line advances on each falling edge of `sclk_i` and not on rising edges.
- R10: In asynchronous mode bit 7 is ignored: `sclk_oe` stays 0 and the frame timing is unchanged.
- R11: No frame starts while bit 5 is 0, or while synchronous mode is selected and `rx_active` is 1. During that time `txd` stays 1, the empty flag stays 1 and the held byte is kept.
- R12: Whenever the shift register is empty, `txd` is 1 and `sclk_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr_en | input | 1 | Control register write strobe |
| csr_wdata | input | 8 | Control register write data |
| csr_rdata | output | 8 | Control and status readback |
| data_valid | input | 1 | Holding stage input valid |
| data_in | input | 8 | Byte to send |
| data_ready | output | 1 | Holding stage can accept |
| baud_tick | input | 1 | One-cycle rate tick from the rate generator |
| rx_active | input | 1 | Receive enable from the receive half; blocks transmit in synchronous mode |
| sclk_i | input | 1 | External bit clock in slave mode |
| txd | output | 1 | Serial data line |
| sclk_o | output | 1 | Generated bit clock in master mode |
| sclk_oe | output | 1 | Clock line drive enable (1 in master mode) |

## Verification
A beat taken on edge P0 loads on edge P1 in every mode when ticks are continuous. From P1 the start bit or bit 0 is on `txd`. In asynchronous mode bit k is sampled at the negedge after P1 + k·D + D/2, where D is 64 or 16. The empty flag is checked low at P1 + N·D − 1 and high at P1 + N·D. In master mode the clock is high after P1 + 2k + 1 and the flag sets at P1 + 2N. In slave mode `sclk_i` is held for four cycles per phase, which covers the three-register edge detector, before each sample. Every check is made on a falling clock edge.

// File: rtl/dstx_pkg.sv
package dstx_pkg;
  typedef struct packed {
    logic csrc;
    logic nine;
    logic txen;
    logic sync;
    logic brgh;
    logic bit9;
  } dstx_ctl_t;

  localparam int F_CSRC  = 7;
  localparam int F_NINE  = 6;
  localparam int F_TXEN  = 5;
  localparam int F_SYNC  = 4;
  localparam int F_BRGH  = 2;
  localparam int F_EMPTY = 1;
  localparam int F_BIT9  = 0;
endpackage

// File: rtl/dstx_csr.sv
module dstx_csr
  import dstx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [7:0] wdata,
  input  logic      empty,
  output dstx_ctl_t ctl,
  output logic [7:0] rdata
);
  logic unused_wbits;
  assign unused_wbits = &{1'b0, wdata[3], wdata[F_EMPTY]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_en) begin
      ctl.csrc <= wdata[F_CSRC];
      ctl.nine <= wdata[F_NINE];
      ctl.txen <= wdata[F_TXEN];
      ctl.sync <= wdata[F_SYNC];
      ctl.brgh <= wdata[F_BRGH];
      ctl.bit9 <= wdata[F_BIT9];
    end
  end

  always_comb begin
    rdata          = '0;
    rdata[F_CSRC]  = ctl.csrc;
    rdata[F_NINE]  = ctl.nine;
    rdata[F_TXEN]  = ctl.txen;
    rdata[F_SYNC]  = ctl.sync;
    rdata[F_BRGH]  = ctl.brgh;
    rdata[F_EMPTY] = empty;
    rdata[F_BIT9]  = ctl.bit9;
  end
endmodule

// File: rtl/dstx_hold.sv
module dstx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  assign in_ready = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (in_valid && in_ready) begin
      full <= 1'b1;
      data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/dstx_engine.sv
module dstx_engine
  import dstx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR_LO = 64,
  parameter int OSR_HI = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dstx_ctl_t         ctl,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              tick,
  input  logic              sclk_in,
  input  logic              rx_active,
  output logic              load,
  output logic              busy,
  output logic              txd,
  output logic              sclk
);
  localparam int SH_W   = DATA_W + 3;
  localparam int CNT_W  = $clog2(OSR_LO);
  localparam int LEFT_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(OSR_LO - 1);
  localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(OSR_HI - 1);

  logic [SH_W-1:0]   sh;
  logic [LEFT_W-1:0] left;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        sin;
  logic              master, slave, allowed, fall, adv;
  logic [SH_W-1:0]   frame;
  logic [LEFT_W-1:0] nbits;

  assign master  = ctl.sync && ctl.csrc;
  assign slave   = ctl.sync && !ctl.csrc;
  assign allowed = ctl.txen && !(ctl.sync && rx_active);
  assign load    = !busy && hold_full && allowed && (slave || tick);
  assign fall    = sin[2] && !sin[1];

  always_comb begin
    if (ctl.sync) begin
      frame = {2'b11, (ctl.nine ? ctl.bit9 : 1'b1), hold_data};
      nbits = LEFT_W'(ctl.nine ? DATA_W + 1 : DATA_W);
    end else begin
      frame = {1'b1, (ctl.nine ? ctl.bit9 : 1'b1), hold_data, 1'b0};
      nbits = LEFT_W'(ctl.nine ? DATA_W + 3 : DATA_W + 2);
    end
  end

  always_comb begin
    if (!busy)       adv = 1'b0;
    else if (!ctl.sync) adv = tick && (cnt == (ctl.brgh ? HI_LAST : LO_LAST));
    else if (master) adv = tick && sclk;
    else             adv = fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sin <= '0;
    else        sin <= {sin[1:0], sclk_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!busy) begin
      cnt  <= '0;
      sclk <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        sh   <= frame;
        left <= nbits - LEFT_W'(1);
      end
    end else begin
      if (!ctl.sync && tick) cnt <= adv ? '0 : cnt + CNT_W'(1);
      if (master && tick)    sclk <= !sclk;
      if (adv) begin
        if (left == '0) begin
          busy <= 1'b0;
        end else begin
          sh   <= {1'b1, sh[SH_W-1:1]};
          left <= left - LEFT_W'(1);
        end
      end
    end
  end

  assign txd = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/dual_serial_tx.sv
module dual_serial_tx
  import dstx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR_LO = 64,
  parameter int OSR_HI = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr_en,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_in,
  output logic              data_ready,
  input  logic              baud_tick,
  input  logic              rx_active,
  input  logic              sclk_i,
  output logic              txd,
  output logic              sclk_o,
  output logic              sclk_oe
);
  dstx_ctl_t         ctl;
  logic              busy, load, hold_full, sclk;
  logic [DATA_W-1:0] hold_data;

  dstx_csr u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_wr_en), .wdata(csr_wdata),
    .empty(!busy), .ctl(ctl), .rdata(csr_rdata)
  );

  dstx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(data_valid), .in_data(data_in),
    .in_ready(data_ready), .take(load), .full(hold_full), .data(hold_data)
  );

  dstx_engine #(.DATA_W(DATA_W), .OSR_LO(OSR_LO), .OSR_HI(OSR_HI)) u_eng (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .hold_full(hold_full),
    .hold_data(hold_data), .tick(baud_tick), .sclk_in(sclk_i),
    .rx_active(rx_active), .load(load), .busy(busy), .txd(txd), .sclk(sclk)
  );

  assign sclk_oe = ctl.sync && ctl.csrc;
  assign sclk_o  = sclk && sclk_oe;
endmodule

// File: rtl/dstx_chk.sv
module dstx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] csr_rdata,
  input logic       data_valid,
  input logic       data_ready,
  input logic       baud_tick,
  input logic       txd,
  input logic       sclk_o,
  input logic       sclk_oe
);
  p_idle_line_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[1] |-> (txd && !sclk_o));

  p_no_clk_drive_async_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rdata[4] |-> !sclk_oe);

  p_accept_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && data_ready) |=> !data_ready);

  p_load_from_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csr_rdata[1]) |-> $past(!data_ready));

  p_disabled_stays_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[1] && !csr_rdata[5]) |=> csr_rdata[1]);

  p_async_moves_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_rdata[4] && !$past(csr_rdata[4]) && (txd != $past(txd))) |-> $past(baud_tick));
endmodule

bind dual_serial_tx dstx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csr_rdata(csr_rdata), .data_valid(data_valid),
  .data_ready(data_ready), .baud_tick(baud_tick), .txd(txd),
  .sclk_o(sclk_o), .sclk_oe(sclk_oe)
);

// File: tb/dual_serial_tx_test.sv
module dual_serial_tx_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csr_wr_en = 1'b0;
  logic [7:0] csr_wdata = '0;
  logic [7:0] csr_rdata;
  logic       data_valid = 1'b0;
  logic [7:0] data_in = '0;
  logic       data_ready;
  logic       baud_tick = 1'b1;
  logic       rx_active = 1'b0;
  logic       sclk_i = 1'b0;
  logic       txd, sclk_o, sclk_oe;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = !clk;

  dual_serial_tx uut (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .data_valid(data_valid), .data_in(data_in),
    .data_ready(data_ready), .baud_tick(baud_tick), .rx_active(rx_active),
    .sclk_i(sclk_i), .txd(txd), .sclk_o(sclk_o), .sclk_oe(sclk_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      summary();
    end
  end

  function automatic logic [7:0] ctlb(bit csrc, bit nine, bit en, bit sy, bit hi, bit b9);
    return {csrc, nine, en, sy, 1'b0, hi, 1'b0, b9};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rx_active = 1'b0; sclk_i = 1'b0; baud_tick = 1'b1;
    data_valid = 1'b0; csr_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_csr(input logic [7:0] v);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  // drives a beat before edge P0; returns at the negedge after P0
  task automatic push(input logic [7:0] d);
    @(negedge clk);
    data_valid = 1'b1; data_in = d;
    @(negedge clk);
    data_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(csr_rdata == 8'h02, "R1 rdata", csr_rdata, 8'h02);
    chk(txd && !sclk_o && !sclk_oe && data_ready, "R1 pins",
        {txd, sclk_o, sclk_oe, data_ready}, 4'b1001);
  endtask

  task automatic t_csr();
    do_reset();
    wr_csr(8'hFF);
    chk(csr_rdata == 8'hF7, "R2 write ones", csr_rdata, 8'hF7);
    wr_csr(8'h00);
    chk(csr_rdata == 8'h02, "R2 write zeros", csr_rdata, 8'h02);
    wr_csr(8'hA5);
    chk(csr_rdata == 8'hA7, "R2 pattern", csr_rdata, 8'hA7);
  endtask

  task automatic t_async(input logic [7:0] d, input bit hi, input bit nine,
                         input bit b9, input bit csrc);
    int div = hi ? 16 : 64;
    int n = nine ? 11 : 10;
    string tag = hi ? "R5" : "R4";
    do_reset();
    wr_csr(ctlb(csrc, nine, 1'b1, 1'b0, hi, b9));
    push(d);
    chk(!data_ready, "R3 ready low after beat", data_ready, 0);
    chk(csr_rdata[1] && txd, "R7 not loaded yet", {csr_rdata[1], txd}, 2'b11);
    @(negedge clk);  // after P1
    chk(!csr_rdata[1], "R7 empty cleared on load", csr_rdata[1], 0);
    chk(data_ready, "R3 ready after load", data_ready, 1);
    chk(!sclk_oe, "R10 no clock drive in async", sclk_oe, 0);
    repeat (div / 2) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      logic e;
      if (k == 0) e = 1'b0;
      else if (k <= 8) e = d[k-1];
      else if (nine && k == 9) e = b9;
      else e = 1'b1;
      chk(txd == e, (nine && k == 9) ? "R6 ninth bit" : (csrc ? "R10 frame" : tag), txd, e);
      if (k < n - 1) repeat (div) @(negedge clk);
    end
    repeat (div / 2 - 1) @(negedge clk);
    chk(!csr_rdata[1], "R7 still busy at last tick", csr_rdata[1], 0);
    @(negedge clk);
    chk(csr_rdata[1] && txd, "R12 empty and idle high", {csr_rdata[1], txd}, 2'b11);
  endtask

  task automatic t_master(input logic [7:0] d, input bit hi, input bit nine, input bit b9);
    int n = nine ? 9 : 8;
    do_reset();
    wr_csr(ctlb(1'b1, nine, 1'b1, 1'b1, hi, b9));
    chk(sclk_oe, "R8 clock drive on", sclk_oe, 1);
    push(d);
    @(negedge clk);
    chk(!sclk_o && txd == d[0], "R8 bit0 clock low", {sclk_o, txd}, {1'b0, d[0]});
    for (int k = 0; k < n; k++) begin
      logic e = (k < 8) ? d[k] : b9;
      @(negedge clk);
      chk(sclk_o && txd == e, (k == 8) ? "R6 sync ninth" : "R8 high phase",
          {sclk_o, txd}, {1'b1, e});
      @(negedge clk);
      chk(!sclk_o, "R8 falling", sclk_o, 0);
      if (k == n - 1) chk(csr_rdata[1], "R7 empty after last bit", csr_rdata[1], 1);
      else chk(!csr_rdata[1] && txd == ((k + 1 < 8) ? d[k+1] : b9), "R8 advance on fall",
               txd, (k + 1 < 8) ? d[k+1] : b9);
    end
  endtask

  task automatic t_slave(input logic [7:0] d);
    do_reset();
    wr_csr(ctlb(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0));
    baud_tick = 1'b0;
    push(d);
    @(negedge clk);
    chk(!sclk_oe && !csr_rdata[1] && txd == d[0], "R9 loads without tick",
        {sclk_oe, csr_rdata[1], txd}, {2'b00, d[0]});
    for (int k = 0; k < 8; k++) begin
      sclk_i = 1'b1;
      repeat (4) @(negedge clk);
      chk(txd == d[k], "R9 rising edge holds", txd, d[k]);
      sclk_i = 1'b0;
      repeat (4) @(negedge clk);
      if (k == 7) chk(csr_rdata[1] && txd, "R9 done after last fall", {csr_rdata[1], txd}, 2'b11);
      else chk(txd == d[k+1], "R9 advance on fall", txd, d[k+1]);
    end
  endtask

  task automatic t_block();
    do_reset();
    wr_csr(ctlb(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    push(8'h3C);
    repeat (20) @(negedge clk);
    chk(csr_rdata[1] && txd && !data_ready, "R11 txen off holds byte",
        {csr_rdata[1], txd, data_ready}, 3'b110);
    rx_active = 1'b1;
    wr_csr(ctlb(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0));
    repeat (20) @(negedge clk);
    chk(csr_rdata[1] && txd && !data_ready && !sclk_o, "R11 receive overrides sync",
        {csr_rdata[1], txd, data_ready, sclk_o}, 4'b1100);
    rx_active = 1'b0;
    repeat (2) @(negedge clk);
    chk(!csr_rdata[1] && data_ready && txd == 1'b0, "R11 released sends bit0",
        {csr_rdata[1], data_ready, txd}, 3'b010);
  endtask

  initial begin
    t_reset();
    t_csr();
    t_async(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);
    t_async(8'h3A, 1'b1, 1'b1, 1'b1, 1'b0);
    t_async(8'hC1, 1'b1, 1'b1, 1'b0, 1'b1);
    t_master(8'h96, 1'b0, 1'b0, 1'b0);
    t_master(8'h5B, 1'b1, 1'b1, 1'b1);
    t_slave(8'hD2);
    t_block();
    summary();
  end
endmodule